// File: doc/BRIEF.md
# PAUSE Flow Control Engine

This block is the flow-control core of a full-duplex Ethernet MAC. On the receive path it takes decoded PAUSE requests from the frame parser. Each request is a one-cycle strobe with a 16-bit duration measured in pause units. The block keeps a countdown and raises `tx_hold` toward the transmit scheduler while the countdown is nonzero. `tx_hold` only blocks the start of new frames. A frame that is already being sent finishes; the scheduler decides this, and the engine has no part in it.

On the transmit path the block watches the local receive buffer. When the buffer's almost-full flag rises, it asks the frame builder to send a PAUSE_ON frame, and it repeats that request while the buffer stays full. When the buffer drains to almost-empty, it asks for a matching PAUSE_OFF frame. Each request is a one-cycle strobe carrying the duration value to put in the frame.

One pause unit is the time to send 512 bits. With a 4-bit-per-clock datapath this is 128 clocks, which is the default prescale. Honouring received PAUSE frames and generating them are switched by separate enables, and both work only when the link is full duplex.

Top module: `pause_flow_ctrl`

## Requirements
- R1: After reset, `tx_hold` and `pause_req` are low and `pause_req_quanta` is zero.
- R2: A received request with a nonzero value Q, while honouring is enabled, raises `tx_hold` in the cycle after the strobe. `tx_hold` stays high for exactly Q×PRESCALE cycles, where PRESCALE defaults to 128 clocks per unit.
- R3: A received request with value zero, while honouring is enabled, clears `tx_hold` in the cycle after the strobe, even if a pause is in progress.
- R4: When the countdown expires without a new nonzero request, `tx_hold` falls by itself.
- R5: A nonzero request received during an active pause replaces the remaining time. The hold then lasts Q×PRESCALE cycles from the new strobe.
- R6: When `rx_pause_en` is low or `full_duplex` is low, received requests are ignored and `tx_hold` is low from the next cycle on. This also cancels any pause in progress.
- R7: A rising edge of `buf_almost_full`, while generation is enabled, gives a one-cycle `pause_req` in the next cycle. The pulse carries the value ON_QUANTA, which defaults to 0xFFFF.
- R8: After a PAUSE_ON request, the first cycle with `buf_almost_empty` high and `buf_almost_full` low gives one `pause_req` with value zero. After that, no further zero-value request is made until another PAUSE_ON has been sent.
- R9: While the peer is paused and `buf_almost_full` stays high, a new PAUSE_ON request with value ON_QUANTA is made (ON_QUANTA/2)×PRESCALE cycles after the previous request. If `buf_almost_full` has fallen by then, no refresh is made.
- R10: When `tx_pause_en` is low or `full_duplex` is low, no `pause_req` is made. `buf_almost_empty` without an earlier PAUSE_ON request gives no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex | input | 1 | Link is in full-duplex mode |
| rx_pause_en | input | 1 | Enable for honouring received PAUSE frames |
| tx_pause_en | input | 1 | Enable for generating PAUSE frames |
| pause_rx_valid | input | 1 | Strobe: a PAUSE frame has been decoded |
| pause_rx_quanta | input | QW | Duration field of the decoded frame, in pause units |
| tx_hold | output | 1 | Blocks the start of new transmit frames |
| buf_almost_full | input | 1 | Local receive buffer is almost full |
| buf_almost_empty | input | 1 | Local receive buffer is almost empty |
| pause_req | output | 1 | One-cycle request to the frame builder to send a PAUSE frame |
| pause_req_quanta | output | QW | Duration value to place in the requested frame |

## Verification
Both outputs are registered, so each result appears one cycle after the edge that samples its stimulus. The bench drives inputs on the falling edge and reads outputs on the next falling edge. The hold length is then counted as the number of falling edges with `tx_hold` high, and it must equal Q×PRESCALE exactly. The refresh interval is counted in the same way, as falling edges from one `pause_req` pulse to the next, and must equal (ON_QUANTA/2)×PRESCALE. The bench uses a small prescale and ON_QUANTA so that every duration from 1 to 6 units and every refresh can be counted cycle by cycle.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  // Clocks between refreshes of PAUSE_ON: half the advertised duration.
  function automatic int unsigned refresh_clocks(int unsigned on_quanta, int unsigned prescale);
    int unsigned half;
    half = (on_quanta / 2) * prescale;
    return (half == 0) ? 1 : half;
  endfunction

  // Total hold length for a given duration value.
  function automatic int unsigned hold_clocks(int unsigned quanta, int unsigned prescale);
    return quanta * prescale;
  endfunction
endpackage

// File: rtl/pfc_pause_timer.sv
module pfc_pause_timer #(
  parameter int QW       = 16,
  parameter int PRESCALE = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          req_valid,
  input  logic [QW-1:0] req_quanta,
  output logic          hold
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

  logic [QW-1:0]   quanta_cnt;
  logic [PS_W-1:0] ps_cnt;

  // Named events for the assertions.
  logic load_evt, wake_evt, unit_tick;
  assign load_evt  = enable && req_valid && (req_quanta != '0);
  assign wake_evt  = enable && req_valid && (req_quanta == '0);
  assign unit_tick = enable && (quanta_cnt != '0) && (ps_cnt == PS_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      quanta_cnt <= '0;
      ps_cnt     <= '0;
    end else if (load_evt) begin
      quanta_cnt <= req_quanta;
      ps_cnt     <= '0;
    end else if (wake_evt) begin
      quanta_cnt <= '0;
      ps_cnt     <= '0;
    end else if (quanta_cnt != '0) begin
      if (unit_tick) begin
        ps_cnt     <= '0;
        quanta_cnt <= quanta_cnt - 1'b1;
      end else begin
        ps_cnt <= ps_cnt + 1'b1;
      end
    end
  end

  assign hold = (quanta_cnt != '0);

  a_r2_hold_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> hold);
  a_r5_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (quanta_cnt == $past(req_quanta)));
  a_r3_wake_releases: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> !hold);
  a_r4_expiry_release: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_tick && quanta_cnt == QW'(1) && !req_valid) |=> !hold);
  a_r6_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !hold);
endmodule

// File: rtl/pfc_pause_gen.sv
module pfc_pause_gen #(
  parameter int          QW        = 16,
  parameter int          PRESCALE  = 128,
  parameter logic [15:0] ON_QUANTA = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          almost_full,
  input  logic          almost_empty,
  output logic          req,
  output logic [QW-1:0] req_quanta
);
  localparam int RW = QW + ((PRESCALE > 1) ? $clog2(PRESCALE) : 1) + 1;
  localparam logic [RW-1:0] REFRESH_LAST =
    RW'(pfc_pkg::refresh_clocks(ON_QUANTA, PRESCALE) - 1);
  localparam logic [QW-1:0] ON_VAL = QW'(ON_QUANTA);

  logic          af_q;
  logic          peer_paused;
  logic [RW-1:0] refresh_cnt;

  // Named events for the assertions.
  logic on_rise, refresh_due, off_due;
  assign on_rise     = enable && almost_full && !af_q;
  assign refresh_due = enable && peer_paused && almost_full && (refresh_cnt == REFRESH_LAST);
  assign off_due     = enable && peer_paused && almost_empty && !almost_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      af_q        <= 1'b0;
      peer_paused <= 1'b0;
      refresh_cnt <= '0;
      req         <= 1'b0;
      req_quanta  <= '0;
    end else begin
      af_q <= almost_full;
      if (!enable) begin
        peer_paused <= 1'b0;
        refresh_cnt <= '0;
        req         <= 1'b0;
      end else begin
        req <= on_rise || refresh_due || off_due;
        if (on_rise || refresh_due) begin
          req_quanta  <= ON_VAL;
          peer_paused <= 1'b1;
          refresh_cnt <= '0;
        end else if (off_due) begin
          req_quanta  <= '0;
          peer_paused <= 1'b0;
          refresh_cnt <= '0;
        end else if (peer_paused && refresh_cnt != REFRESH_LAST) begin
          refresh_cnt <= refresh_cnt + 1'b1;
        end
      end
    end
  end

  a_r7_on_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    on_rise |=> (req && req_quanta == ON_VAL));
  a_r9_refresh_value: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_due |=> (req && req_quanta == ON_VAL));
  a_r8_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    off_due |=> (req && req_quanta == '0 && !peer_paused));
  a_r10_silent_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !req);
endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl #(
  parameter int          QW        = 16,
  parameter int          PRESCALE  = 128,
  parameter logic [15:0] ON_QUANTA = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          full_duplex,
  input  logic          rx_pause_en,
  input  logic          tx_pause_en,
  input  logic          pause_rx_valid,
  input  logic [QW-1:0] pause_rx_quanta,
  output logic          tx_hold,
  input  logic          buf_almost_full,
  input  logic          buf_almost_empty,
  output logic          pause_req,
  output logic [QW-1:0] pause_req_quanta
);
  logic honour_en, gen_en;
  assign honour_en = full_duplex && rx_pause_en;
  assign gen_en    = full_duplex && tx_pause_en;

  pfc_pause_timer #(.QW(QW), .PRESCALE(PRESCALE)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (honour_en),
    .req_valid  (pause_rx_valid),
    .req_quanta (pause_rx_quanta),
    .hold       (tx_hold)
  );

  pfc_pause_gen #(.QW(QW), .PRESCALE(PRESCALE), .ON_QUANTA(ON_QUANTA)) u_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (gen_en),
    .almost_full  (buf_almost_full),
    .almost_empty (buf_almost_empty),
    .req          (pause_req),
    .req_quanta   (pause_req_quanta)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> (!tx_hold && !pause_req && pause_req_quanta == '0));
endmodule

// File: tb/test_pause_flow_ctrl.sv
`timescale 1ns/1ps
module test_pause_flow_ctrl;
  localparam int          QW = 16;
  localparam int          PS = 8;
  localparam logic [15:0] ONQ = 16'h000A;
  localparam int          REFRESH = (ONQ / 2) * PS;

  logic clk = 1'b0;
  logic rst_n;
  logic full_duplex, rx_pause_en, tx_pause_en;
  logic pause_rx_valid;
  logic [QW-1:0] pause_rx_quanta;
  logic tx_hold;
  logic buf_almost_full, buf_almost_empty;
  logic pause_req;
  logic [QW-1:0] pause_req_quanta;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pause_flow_ctrl #(.QW(QW), .PRESCALE(PS), .ON_QUANTA(ONQ)) i_pause_flow_ctrl (
    .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex),
    .rx_pause_en(rx_pause_en), .tx_pause_en(tx_pause_en),
    .pause_rx_valid(pause_rx_valid), .pause_rx_quanta(pause_rx_quanta),
    .tx_hold(tx_hold), .buf_almost_full(buf_almost_full),
    .buf_almost_empty(buf_almost_empty), .pause_req(pause_req),
    .pause_req_quanta(pause_req_quanta)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One-cycle received request; returns at the cycle after it was sampled.
  task automatic send_pause(input logic [QW-1:0] q);
    pause_rx_valid  = 1'b1;
    pause_rx_quanta = q;
    @(negedge clk);
    pause_rx_valid  = 1'b0;
  endtask

  task automatic count_hold(output int n);
    n = 0;
    while (tx_hold && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic cycles_to_req(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pause_req && n < limit);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; full_duplex = 1'b1; rx_pause_en = 1'b1; tx_pause_en = 1'b1;
    pause_rx_valid = 1'b0; pause_rx_quanta = '0;
    buf_almost_full = 1'b0; buf_almost_empty = 1'b0;
    cyc(3);
    // R1: reset state
    check(!tx_hold && !pause_req && pause_req_quanta == 0, "R1", {tx_hold, pause_req}, 0);
    rst_n = 1'b1;
    cyc(2);

    // R2 / R4: hold length sweep, self release
    for (int q = 1; q <= 6; q++) begin
      send_pause(QW'(q));
      check(tx_hold, "R2", tx_hold, 1);
      count_hold(n);
      check(n == q * PS, "R2", n, q * PS);
      check(!tx_hold, "R4", tx_hold, 0);
      cyc(3);
    end

    // R5: reload during an active pause
    send_pause(QW'(6));
    cyc(5);
    send_pause(QW'(2));
    count_hold(n);
    check(n == 2 * PS, "R5", n, 2 * PS);
    cyc(2);

    // R3: zero value wakes at once
    send_pause(QW'(6));
    cyc(3);
    send_pause(QW'(0));
    check(!tx_hold, "R3", tx_hold, 0);
    cyc(2);

    // R6: honouring disabled / half duplex ignore requests; disable cancels
    rx_pause_en = 1'b0;
    send_pause(QW'(3));
    check(!tx_hold, "R6", tx_hold, 0);
    rx_pause_en = 1'b1; full_duplex = 1'b0;
    send_pause(QW'(3));
    check(!tx_hold, "R6", tx_hold, 0);
    full_duplex = 1'b1;
    send_pause(QW'(5));
    cyc(2);
    rx_pause_en = 1'b0;
    cyc(1);
    check(!tx_hold, "R6", tx_hold, 0);
    rx_pause_en = 1'b1;
    cyc(2);

    // R10: almost-empty with no prior PAUSE_ON gives no request
    buf_almost_empty = 1'b1;
    cycles_to_req(20, n);
    check(!pause_req, "R10", pause_req, 0);
    buf_almost_empty = 1'b0;

    // R7: rising almost-full requests PAUSE_ON next cycle
    buf_almost_full = 1'b1;
    @(negedge clk);
    check(pause_req && pause_req_quanta == ONQ, "R7", pause_req_quanta, ONQ);
    @(negedge clk);
    check(!pause_req, "R7", pause_req, 0);

    // R9: refresh interval while still almost full
    cycles_to_req(REFRESH + 20, n);
    check(n == REFRESH - 1, "R9", n, REFRESH - 1);
    check(pause_req_quanta == ONQ, "R9", pause_req_quanta, ONQ);
    cycles_to_req(REFRESH + 20, n);
    check(n == REFRESH, "R9", n, REFRESH);

    // R8: drain gives one PAUSE_OFF
    buf_almost_full = 1'b0;
    buf_almost_empty = 1'b1;
    @(negedge clk);
    check(pause_req && pause_req_quanta == 0, "R8", pause_req_quanta, 0);
    cycles_to_req(REFRESH + 20, n);
    check(!pause_req, "R8", pause_req, 0);
    buf_almost_empty = 1'b0;

    // R9: no refresh once almost-full has fallen
    buf_almost_full = 1'b1;
    @(negedge clk);
    check(pause_req && pause_req_quanta == ONQ, "R7", pause_req_quanta, ONQ);
    buf_almost_full = 1'b0;
    cycles_to_req(REFRESH + 20, n);
    check(!pause_req, "R9", pause_req, 0);
    buf_almost_empty = 1'b1;
    @(negedge clk);
    check(pause_req && pause_req_quanta == 0, "R8", pause_req_quanta, 0);
    buf_almost_empty = 1'b0;
    cyc(2);

    // R10: generation disabled or half duplex
    tx_pause_en = 1'b0;
    buf_almost_full = 1'b1;
    cycles_to_req(10, n);
    check(!pause_req, "R10", pause_req, 0);
    buf_almost_full = 1'b0;
    tx_pause_en = 1'b1; full_duplex = 1'b0;
    cyc(1);
    buf_almost_full = 1'b1;
    cycles_to_req(10, n);
    check(!pause_req, "R10", pause_req, 0);
    buf_almost_full = 1'b0;
    full_duplex = 1'b1;
    cyc(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule